// File: doc/BRIEF.md
# Oscillator Warm-Up Timer

This block delays the use of a freshly enabled high-speed oscillator until a programmed number of its cycles has gone by. Software (or a clock-switch sequencer) writes a source select and a 12-bit coarse count, then sets a start bit. The timer counts pulses on the count-enable input of the selected oscillator. It raises a busy flag while counting and emits a one-cycle done pulse when the wait has elapsed.

The full count is 16 bits wide. Only its upper 12 bits are programmable, and the low 4 bits are always zero, so each unit of the field stands for 16 oscillator cycles. Software derives the field as the wanted warm-up time divided by the oscillator period, divided by 16. While busy is high the settings are frozen. On wake from the low-power stop state, a wake strobe selects the internal oscillator and starts the count with the stored field, with no software action.

Top module: `osc_warmup_timer`

## Requirements
- R1: After reset, busy, done, cfg_src and cfg_count are all 0.
- R2: A write (wr_en=1) while busy is 0 loads wr_src into cfg_src and wr_count into cfg_count, both visible one cycle later. A write with wr_start=0 leaves busy at 0.
- R3: A write with wr_start=1 while busy is 0 sets busy to 1 in the following cycle. The count uses the value written in that same write.
- R4: For a field F greater than 0, the count is the 16-bit value F*16 (low 4 bits zero). Busy clears on the F*16-th selected tick, whether ticks arrive every cycle or with gaps.
- R5: A field of 0 finishes on the first selected tick and never hangs.
- R6: Source encoding: cfg_src=0 counts tick_int (internal oscillator) and cfg_src=1 counts tick_ext (external oscillator). Pulses on the other input have no effect.
- R7: While busy is 1, writes are ignored. cfg_src and cfg_count keep their values, and a start bit in such a write does not alter the running count.
- R8: done is high for exactly one cycle, in the same cycle in which busy first reads 0 after a count.
- R9: A stop_wake strobe while busy is 0 forces cfg_src to 0 and starts a count with the stored field. The strobe takes priority over a write in the same cycle, so that write is dropped. While busy is 1, stop_wake is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_src | input | 1 | Source select to write (0 internal, 1 external) |
| wr_count | input | 12 | Coarse count field to write (units of 16 ticks) |
| wr_start | input | 1 | Start bit carried by the write |
| stop_wake | input | 1 | Wake-from-stop strobe: internal source, automatic start |
| tick_int | input | 1 | Count enable from the internal oscillator |
| tick_ext | input | 1 | Count enable from the external oscillator |
| busy | output | 1 | Warm-up in progress |
| done | output | 1 | One-cycle pulse at the end of warm-up |
| cfg_src | output | 1 | Read-back of the stored source select |
| cfg_count | output | 12 | Read-back of the stored count field |

## Verification
An accepted write shows on the read-back ports, and busy rises, one clock after the write edge. The terminal tick is sampled on an edge, and that same edge drops busy and raises done. done falls again one edge later. The bench drives every input on the falling clock edge and samples the outputs on the next falling edge. It counts only the ticks it actually applied to the selected input, so each result is compared in the cycle in which it is due.

// File: rtl/wu_pkg.sv
// Shared sizing for the oscillator warm-up timer.
// Assumes the fine part of the count is never programmable.
package wu_pkg;
    localparam int WU_CNT_W  = 16;  // full warm-up count width
    localparam int WU_FRAC_W = 4;   // low bits forced to zero
    typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} wu_src_e;
endpackage

// File: rtl/wu_cfg_reg.sv
// Control register of the warm-up timer: source select and coarse field.
// Assumes busy comes from the counter; every update is blocked while it is high.
// Produces the launch request and the field the counter must load.
module wu_cfg_reg #(
    parameter int FIELD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               wr_en,
    input  logic               wr_src,
    input  logic [FIELD_W-1:0] wr_field,
    input  logic               wr_start,
    input  logic               wake,
    output logic               src_q,
    output logic [FIELD_W-1:0] field_q,
    output logic               launch,
    output logic [FIELD_W-1:0] load_field
);
    logic wake_ok;
    logic wr_ok;

    // Decide which request is accepted this cycle; wake wins over a write.
    always_comb begin
        wake_ok    = wake && !busy;
        wr_ok      = wr_en && !busy && !wake;
        launch     = wake_ok || (wr_ok && wr_start);
        load_field = wake_ok ? field_q : wr_field;
    end

    // Hold the settings, updated only by an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= wu_pkg::SRC_INT;
            field_q <= '0;
        end else if (wake_ok) begin
            src_q   <= wu_pkg::SRC_INT;
        end else if (wr_ok) begin
            src_q   <= wr_src;
            field_q <= wr_field;
        end
    end
endmodule

// File: rtl/wu_tick_sel.sv
// Picks the count enable of the selected oscillator.
// Assumes both tick inputs are already synchronous to clk.
module wu_tick_sel #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0]         ticks,
    input  logic [$clog2(N_SRC)-1:0] sel,
    output logic                     tick
);
    // Forward only the tick of the selected source.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N_SRC; i++)
            if (sel == i[$clog2(N_SRC)-1:0]) tick = ticks[i];
    end
endmodule

// File: rtl/wu_down_cnt.sv
// Warm-up down counter. It loads the coarse field shifted left by FRAC_W,
// steps down on each selected tick, and ends on the tick that finds 1 or 0.
// So a zero field ends after one tick and a field F ends after F*2^FRAC_W ticks.
module wu_down_cnt #(
    parameter int CNT_W  = 16,
    parameter int FRAC_W = 4,
    localparam int FIELD_W = CNT_W - FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [FIELD_W-1:0] load_field,
    input  logic               tick,
    output logic               busy,
    output logic               done
);
    logic [CNT_W-1:0] cnt;
    logic             last;

    // Terminal test: this tick is the final one.
    always_comb last = (cnt <= CNT_W'(1));

    // Count state, busy flag and the single-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                cnt  <= {load_field, {FRAC_W{1'b0}}};
                busy <= 1'b1;
            end else if (busy && tick) begin
                if (last) begin
                    cnt  <= '0;
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/osc_warmup_timer.sv
// Top of the oscillator warm-up timer. It joins the control register,
// the tick selector and the down counter. All inputs are synchronous to clk.
module osc_warmup_timer #(
    parameter int CNT_W   = wu_pkg::WU_CNT_W,
    parameter int FRAC_W  = wu_pkg::WU_FRAC_W,
    parameter int FIELD_W = CNT_W - FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_src,
    input  logic [FIELD_W-1:0] wr_count,
    input  logic               wr_start,
    input  logic               stop_wake,
    input  logic               tick_int,
    input  logic               tick_ext,
    output logic               busy,
    output logic               done,
    output logic               cfg_src,
    output logic [FIELD_W-1:0] cfg_count
);
    logic               launch;
    logic [FIELD_W-1:0] load_field;
    logic               tick_sel;

    wu_cfg_reg #(.FIELD_W(FIELD_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .wr_en(wr_en), .wr_src(wr_src), .wr_field(wr_count),
        .wr_start(wr_start), .wake(stop_wake),
        .src_q(cfg_src), .field_q(cfg_count),
        .launch(launch), .load_field(load_field)
    );

    wu_tick_sel #(.N_SRC(2)) i_sel (
        .ticks({tick_ext, tick_int}), .sel(cfg_src), .tick(tick_sel)
    );

    wu_down_cnt #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .launch(launch), .load_field(load_field),
        .tick(tick_sel), .busy(busy), .done(done)
    );
endmodule

// File: rtl/wu_checker.sv
// Port-level properties of the warm-up timer, bound to the top module.
module wu_checker #(
    parameter int FIELD_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               wr_start,
    input logic               stop_wake,
    input logic               tick_int,
    input logic               tick_ext,
    input logic               busy,
    input logic               done,
    input logic               cfg_src,
    input logic [FIELD_W-1:0] cfg_count
);
    logic tk;
    always_comb tk = cfg_src ? tick_ext : tick_int;

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_start && !busy && !stop_wake) |=> busy);
    p_zero_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_count == '0 && tk) |=> (done && !busy));
    p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tk) |=> busy);
    p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cfg_count) && $stable(cfg_src)));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_with_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wake && !busy) |=> (busy && !cfg_src));
endmodule

bind osc_warmup_timer wu_checker #(.FIELD_W(FIELD_W)) i_wu_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
    .stop_wake(stop_wake), .tick_int(tick_int), .tick_ext(tick_ext),
    .busy(busy), .done(done), .cfg_src(cfg_src), .cfg_count(cfg_count)
);

// File: tb/test_osc_warmup_timer.sv
module test_osc_warmup_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_src = 0, wr_start = 0, stop_wake = 0;
    logic [11:0] wr_count = '0;
    logic        tick_int = 0, tick_ext = 0;
    logic        busy, done, cfg_src;
    logic [11:0] cfg_count;
    int          n_chk = 0, n_bad = 0;
    int          cyc = 0;

    always #2.5 clk = ~clk;

    osc_warmup_timer i_osc_warmup_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_src(wr_src),
        .wr_count(wr_count), .wr_start(wr_start), .stop_wake(stop_wake),
        .tick_int(tick_int), .tick_ext(tick_ext), .busy(busy), .done(done),
        .cfg_src(cfg_src), .cfg_count(cfg_count)
    );

    // vector: {src, field, gap}
    localparam logic [13:0] VEC [6] = '{
        {1'b0, 12'd1, 1'b0}, {1'b1, 12'd2, 1'b0}, {1'b0, 12'd0, 1'b0},
        {1'b1, 12'd0, 1'b1}, {1'b0, 12'd3, 1'b1}, {1'b1, 12'd5, 1'b0}};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [11:0] f, input logic st, input logic wk);
        wr_en = 1; wr_src = s; wr_count = f; wr_start = st; stop_wake = wk;
        @(posedge clk); @(negedge clk);
        wr_en = 0; wr_start = 0; stop_wake = 0;
    endtask

    // Apply ticks to the chosen input (other input held high) until busy
    // falls; returns the number of selected ticks given.
    task automatic run(input logic s, input logic gap, input int lim,
                       input logic mid_poke, output int n);
        logic give;
        n = 0;
        for (int k = 0; k < lim; k++) begin
            give = gap ? k[0] : 1'b1;
            tick_int = s ? 1'b1 : give;
            tick_ext = s ? give : 1'b1;
            if (mid_poke && k == 3) begin
                wr_en = 1; wr_src = ~s; wr_count = 12'd7; wr_start = 1; stop_wake = 1;
            end
            @(posedge clk); @(negedge clk);
            wr_en = 0; wr_start = 0; stop_wake = 0;
            if (give) n++;
            if (!busy) break;
        end
        tick_int = 0; tick_ext = 0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy", busy, 0); chk("R1 done", done, 0);
        chk("R1 src", cfg_src, 0); chk("R1 count", cfg_count, 0);

        wr(1'b1, 12'h5A, 1'b0, 1'b0);
        chk("R2 src", cfg_src, 1); chk("R2 count", cfg_count, 12'h5A);
        chk("R2 idle", busy, 0);

        foreach (VEC[i]) begin
            int exp_n;
            exp_n = (VEC[i][12:1] == 0) ? 1 : 16 * VEC[i][12:1];
            wr(VEC[i][13], VEC[i][12:1], 1'b1, 1'b0);
            chk("R3 busy after start", busy, 1);
            run(VEC[i][13], VEC[i][0], 4 * exp_n + 8, 1'b0, n);
            chk(VEC[i][12:1] == 0 ? "R5 zero field ticks" : "R4/R6 ticks", n, exp_n);
            chk("R8 done with busy fall", done, 1);
            @(negedge clk);
            chk("R8 done single", done, 0);
        end

        // R4 largest field
        wr(1'b0, 12'hFFF, 1'b1, 1'b0);
        run(1'b0, 1'b0, 70000, 1'b0, n);
        chk("R4 max field ticks", n, 65520);

        // R7 writes, start and wake ignored while busy
        wr(1'b0, 12'd2, 1'b1, 1'b0);
        run(1'b0, 1'b0, 100, 1'b1, n);
        chk("R7 ticks unchanged", n, 32);
        chk("R7 src kept", cfg_src, 0); chk("R7 count kept", cfg_count, 2);

        // R9 wake: internal forced, stored field used, write dropped
        wr(1'b1, 12'd1, 1'b0, 1'b0);
        chk("R2 src ext", cfg_src, 1);
        wr(1'b1, 12'd9, 1'b1, 1'b1);
        chk("R9 busy", busy, 1); chk("R9 src int", cfg_src, 0);
        chk("R9 count kept", cfg_count, 1);
        run(1'b0, 1'b0, 100, 1'b0, n);
        chk("R9 ticks", n, 16);

        // R1 reset mid-count
        wr(1'b1, 12'd4, 1'b1, 1'b0);
        rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
        chk("R1 busy after reset", busy, 0); chk("R1 src after reset", cfg_src, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule